// File: doc/BRIEF.md
# Multi-Channel Timer Start Controller

This block is a bank of independent 16-bit timer channels that share one count-clock enable pulse. Software controls it through a small word-wide register bus. A write-only start register arms channels, and a write-only stop register disarms them. A read-only status word shows which channels are running. Each channel also has a data register and a counter, and both can be read back.

Each channel runs in one of three modes, chosen by a 2-bit pin field. The mode decides how the counter begins after a start:

- **Interval mode** waits for the next count pulse, loads the data value, and then counts down.
- **Event mode** loads the data value at the moment of the start write. After that it counts down on rising edges of its event pin.
- **Capture mode** waits for the next count pulse, clears the counter, and then counts up. A rising edge on its capture pin stores the counter into the data register.

A typical use is periodic interrupts, pulse counting or period measurement. Each channel's interrupt is a one-cycle pulse.

Top module: `tmr_start_ctrl`

## Requirements
- R1: Writing the start register (address 0) with bit n set, for n in 0..11, sets bit n of the status word (address 2). Bits 15..12 of that write change nothing.
- R2: Reading the start register (address 0) or the stop register (address 1) always returns 0000H.
- R3: Writing the stop register with bit n set clears status bit n. While channel n is disabled, its counter (address 32+n) keeps its value through count pulses.
- R4: In interval mode (mode code 00, and 11 behaves the same), the counter does not change between the start write and the next count pulse. That pulse loads the data register (address 16+n), and each later pulse decrements the counter by one.
- R5: In interval mode, a count pulse that finds the counter at 0000H reloads it from the data register. The channel's interrupt is then high for exactly one cycle.
- R6: In event mode (code 01), the start write loads the data register into the counter in the same clock edge, with no count pulse needed.
- R7: In event mode, the event pin is sampled on count pulses, and a rising edge between two samples decrements the counter. An edge that finds the counter at 1 (or 0) reloads it from the data register instead and pulses the interrupt for one cycle. Event edges never enable a stopped channel and never move its counter.
- R8: In capture mode (code 10), the first count pulse after a start loads 0000H, and each later pulse increments the counter.
- R9: In capture mode, a rising edge on the capture pin of a running channel does three things: it copies the counter into the data register, clears the counter and pulses the interrupt. If a bus write to that data register happens in the same cycle, the captured value is kept.
- R10: After reset, every status bit, counter, data register and interrupt is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Register address: 0 start, 1 stop, 2 status, 16+n data, 32+n counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cnt_tick | input | 1 | Shared one-cycle count-clock enable |
| chan_mode | input | 24 | Two mode bits per channel; channel n uses bits 2n+1..2n |
| evt_in | input | 12 | Per-channel event inputs |
| cap_in | input | 12 | Per-channel capture inputs |
| irq_out | output | 12 | Per-channel one-cycle interrupt pulses |

## Verification
Most internal faults in this block become visible on the bus within one or two count pulses.

- A deferred-load flag left set or cleared by mistake shows up at the first count pulse after a start, as a counter holding the wrong value (the data value, zero or a stale count).
- A wrong enable bit shows up in the status word right after the write.
- A counter that moves while its channel is stopped shows up at the next count pulse.
- An edge detector whose history register is wrong gives a missed or extra decrement at the following sampled edge.
- A wrong capture priority leaves the bus-written value, rather than the captured value, in the data register in the cycle after the collision.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_EVENT    = 2'b01,
        MODE_CAPTURE  = 2'b10
    } tmr_mode_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
    parameter int NCH       = 12,
    parameter int CW        = 16,
    parameter int AW        = 6,
    parameter int A_START   = 0,
    parameter int A_STOP    = 1,
    parameter int A_STATUS  = 2,
    parameter int DATA_BASE = 16,
    parameter int CNT_BASE  = 32
) (
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [CW-1:0]          bus_wdata,
    output logic [CW-1:0]          bus_rdata,
    output logic [NCH-1:0]         start_vec,
    output logic [NCH-1:0]         stop_vec,
    output logic [NCH-1:0]         data_we,
    input  logic [NCH-1:0]         en_vec,
    input  logic [NCH-1:0][CW-1:0] data_vec,
    input  logic [NCH-1:0][CW-1:0] cnt_vec
);
    // Write decode: only the channel bits of the start and stop words reach the channels.
    always_comb begin
        start_vec = '0;
        stop_vec  = '0;
        data_we   = '0;
        if (bus_wr) begin
            if (bus_addr == AW'(A_START)) start_vec = bus_wdata[NCH-1:0];
            if (bus_addr == AW'(A_STOP))  stop_vec  = bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(DATA_BASE + i)) data_we[i] = 1'b1;
            end
        end
    end

    // Read mux: the trigger registers are write-only and always return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_STATUS)) bus_rdata[NCH-1:0] = en_vec;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(DATA_BASE + i)) bus_rdata = data_vec[i];
            if (bus_addr == AW'(CNT_BASE + i))  bus_rdata = cnt_vec[i];
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  tmr_mode_e     mode,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          data_we,
    input  logic [CW-1:0] wdata,
    input  logic          evt_in,
    input  logic          cap_in,
    output logic          en_o,
    output logic [CW-1:0] data_o,
    output logic [CW-1:0] cnt_o,
    output logic          irq_o
);
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic          en;
        logic          pend;
        logic [CW-1:0] cnt;
        logic [CW-1:0] data;
        logic          evt_last;
        logic          cap_last;
        logic          irq;
    } ch_state_t;

    ch_state_t q, n;
    logic evt_edge_d, cap_edge_d;

    always_comb begin
        n          = q;
        n.irq      = 1'b0;
        n.cap_last = cap_in;
        cap_edge_d = cap_in & ~q.cap_last;
        evt_edge_d = tick & evt_in & ~q.evt_last;
        if (tick) n.evt_last = evt_in;
        if (data_we) n.data = wdata;

        if (start_i) begin
            n.en = 1'b1;
            if (mode == MODE_EVENT) begin
                n.cnt  = q.data;
                n.pend = 1'b0;
            end else begin
                n.pend = 1'b1;
            end
        end else if (stop_i) begin
            n.en   = 1'b0;
            n.pend = 1'b0;
        end else if (q.en) begin
            case (mode)
                MODE_CAPTURE: begin
                    if (cap_edge_d) begin
                        n.data = q.cnt;
                        n.cnt  = ZERO;
                        n.pend = 1'b0;
                        n.irq  = 1'b1;
                    end else if (tick) begin
                        if (q.pend) begin
                            n.cnt  = ZERO;
                            n.pend = 1'b0;
                        end else begin
                            n.cnt = q.cnt + ONE;
                        end
                    end
                end
                MODE_EVENT: begin
                    if (evt_edge_d) begin
                        if (q.cnt <= ONE) begin
                            n.cnt = q.data;
                            n.irq = 1'b1;
                        end else begin
                            n.cnt = q.cnt - ONE;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (q.pend) begin
                            n.cnt  = q.data;
                            n.pend = 1'b0;
                        end else if (q.cnt == ZERO) begin
                            n.cnt = q.data;
                            n.irq = 1'b1;
                        end else begin
                            n.cnt = q.cnt - ONE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign en_o   = q.en;
    assign data_o = q.data;
    assign cnt_o  = q.cnt;
    assign irq_o  = q.irq;

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !start_i) |=> $stable(q.cnt));

    // R6
    evt_start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode == MODE_EVENT) |=> (q.cnt == $past(q.data)));

    // R4
    ivl_first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && q.pend && tick && !start_i && !stop_i && mode == MODE_INTERVAL)
        |=> (q.cnt == $past(q.data)));

    // R8
    cap_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && q.pend && tick && !start_i && !stop_i && mode == MODE_CAPTURE)
        |=> (q.cnt == ZERO));

    // R5
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> $past(q.en));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !$past(start_i)) |=> !q.irq || (mode == MODE_CAPTURE) || (mode == MODE_EVENT));
endmodule

// File: rtl/tmr_start_ctrl.sv
module tmr_start_ctrl
    import tmr_pkg::*;
#(
    parameter int NCH = 12,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CW-1:0]    bus_wdata,
    output logic [CW-1:0]    bus_rdata,
    input  logic             cnt_tick,
    input  logic [2*NCH-1:0] chan_mode,
    input  logic [NCH-1:0]   evt_in,
    input  logic [NCH-1:0]   cap_in,
    output logic [NCH-1:0]   irq_out
);
    localparam int DATA_BASE = 16;
    localparam int CNT_BASE  = 2 * DATA_BASE;

    logic [NCH-1:0]         start_vec, stop_vec, data_we, en_vec;
    logic [NCH-1:0][CW-1:0] data_vec, cnt_vec;

    tmr_bus_decode #(
        .NCH(NCH), .CW(CW), .AW(AW),
        .A_START(0), .A_STOP(1), .A_STATUS(2),
        .DATA_BASE(DATA_BASE), .CNT_BASE(CNT_BASE)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .start_vec(start_vec),
        .stop_vec (stop_vec),
        .data_we  (data_we),
        .en_vec   (en_vec),
        .data_vec (data_vec),
        .cnt_vec  (cnt_vec)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (cnt_tick),
            .mode   (tmr_mode_e'(chan_mode[2*g +: 2])),
            .start_i(start_vec[g]),
            .stop_i (stop_vec[g]),
            .data_we(data_we[g]),
            .wdata  (bus_wdata),
            .evt_in (evt_in[g]),
            .cap_in (cap_in[g]),
            .en_o   (en_vec[g]),
            .data_o (data_vec[g]),
            .cnt_o  (cnt_vec[g]),
            .irq_o  (irq_out[g])
        );
    end

    // R1
    start_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(0)) |=> ((en_vec & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));
endmodule

// File: tb/tmr_start_ctrl_test.sv
module tmr_start_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cnt_tick = 1'b0;
    logic [23:0] chan_mode;
    logic [11:0] evt_in = '0;
    logic [11:0] cap_in = '0;
    logic [11:0] irq_out;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // ch0 interval (00), ch1 event (01), ch2 capture (10), the rest interval
    assign chan_mode = 24'b0000_0000_0000_0000_0010_0100;

    always #10 clk = ~clk;

    tmr_start_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
        .chan_mode(chan_mode), .evt_in(evt_in), .cap_in(cap_in), .irq_out(irq_out)
    );

    // {op[1:0], req[3:0], addr[5:0], value[15:0]}; op 0 write, 1 tick, 2 read-check
    localparam int NV = 31;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {2'd0, 4'd4,  6'd16, 16'h0003},  // R4 data0 = 3
        {2'd0, 4'd1,  6'd0,  16'h0001},  // R1 start ch0
        {2'd2, 4'd1,  6'd2,  16'h0001},  // R1 status
        {2'd2, 4'd2,  6'd0,  16'h0000},  // R2 start reads zero
        {2'd2, 4'd4,  6'd32, 16'h0000},  // R4 no load before pulse
        {2'd1, 4'd4,  6'd0,  16'h0000},
        {2'd2, 4'd4,  6'd32, 16'h0003},  // R4 first pulse loads
        {2'd1, 4'd4,  6'd0,  16'h0000},
        {2'd2, 4'd4,  6'd32, 16'h0002},  // R4 decrement
        {2'd0, 4'd3,  6'd1,  16'h0001},  // R3 stop ch0
        {2'd2, 4'd3,  6'd2,  16'h0000},  // R3 status cleared
        {2'd2, 4'd2,  6'd1,  16'h0000},  // R2 stop reads zero
        {2'd1, 4'd3,  6'd0,  16'h0000},
        {2'd2, 4'd3,  6'd32, 16'h0002},  // R3 held
        {2'd0, 4'd6,  6'd17, 16'h0005},  // R6 data1 = 5
        {2'd0, 4'd6,  6'd0,  16'h0002},  // R6 start ch1
        {2'd2, 4'd6,  6'd33, 16'h0005},  // R6 immediate load
        {2'd2, 4'd1,  6'd2,  16'h0002},  // R1 status
        {2'd1, 4'd7,  6'd0,  16'h0000},
        {2'd2, 4'd7,  6'd33, 16'h0005},  // R7 no edge, no change
        {2'd0, 4'd1,  6'd0,  16'hF000},  // R1 reserved bits only
        {2'd2, 4'd1,  6'd2,  16'h0002},  // R1 unchanged
        {2'd0, 4'd8,  6'd18, 16'h1234},  // R8 data2
        {2'd0, 4'd8,  6'd0,  16'h0004},  // R8 start ch2
        {2'd1, 4'd8,  6'd0,  16'h0000},
        {2'd2, 4'd8,  6'd34, 16'h0000},  // R8 first pulse clears
        {2'd1, 4'd8,  6'd0,  16'h0000},
        {2'd2, 4'd8,  6'd34, 16'h0001},  // R8 count up
        {2'd1, 4'd8,  6'd0,  16'h0000},
        {2'd2, 4'd8,  6'd34, 16'h0002},  // R8 count up
        {2'd2, 4'd8,  6'd18, 16'h1234}   // R8 data kept
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        cnt_tick = 1'b1;
        @(posedge clk); #1;
        cnt_tick = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic chk_rd(input string req, input logic [5:0] a, input logic [15:0] exp);
        bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk_rd("R10", 6'd2, 16'h0000);
        chk_rd("R10", 6'd32, 16'h0000);
        chk_rd("R10", 6'd16, 16'h0000);
        check("R10", {4'h0, irq_out}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][27:26])
                2'd0: do_write(VEC[i][21:16], VEC[i][15:0]);
                2'd1: do_tick();
                default: chk_rd($sformatf("R%0d", VEC[i][25:22]), VEC[i][21:16], VEC[i][15:0]);
            endcase
        end

        // R7 event edges sampled on count pulses
        evt_in[1] = 1'b1; do_tick();
        chk_rd("R7", 6'd33, 16'h0004);
        do_tick();
        chk_rd("R7", 6'd33, 16'h0004);
        evt_in[1] = 1'b0; do_tick();
        evt_in[1] = 1'b1; do_tick();
        chk_rd("R7", 6'd33, 16'h0003);
        // R7 events on a stopped channel change nothing
        do_write(6'd1, 16'h0002);
        evt_in[1] = 1'b0; do_tick();
        evt_in[1] = 1'b1; do_tick();
        chk_rd("R7", 6'd33, 16'h0003);
        chk_rd("R7", 6'd2, 16'h0004);
        // R7 reload at one
        do_write(6'd17, 16'h0002);
        do_write(6'd0, 16'h0002);
        chk_rd("R6", 6'd33, 16'h0002);
        evt_in[1] = 1'b0; do_tick();
        evt_in[1] = 1'b1; do_tick();
        chk_rd("R7", 6'd33, 16'h0001);
        evt_in[1] = 1'b0; do_tick();
        evt_in[1] = 1'b1; do_tick();
        check("R7", {15'd0, irq_out[1]}, 16'h0001);
        chk_rd("R7", 6'd33, 16'h0002);
        idle();
        check("R7", {15'd0, irq_out[1]}, 16'h0000);

        // R5 interval wrap on channel 0
        do_write(6'd16, 16'h0001);
        do_write(6'd0, 16'h0001);
        do_tick();
        chk_rd("R5", 6'd32, 16'h0001);
        do_tick();
        chk_rd("R5", 6'd32, 16'h0000);
        check("R5", {15'd0, irq_out[0]}, 16'h0000);
        do_tick();
        check("R5", {15'd0, irq_out[0]}, 16'h0001);
        chk_rd("R5", 6'd32, 16'h0001);
        idle();
        check("R5", {15'd0, irq_out[0]}, 16'h0000);

        // R9 capture beats a same-cycle bus write
        do_write(6'd0, 16'h0004);
        repeat (4) do_tick();
        chk_rd("R8", 6'd34, 16'h0003);
        @(negedge clk);
        cap_in[2] = 1'b1; bus_wr = 1'b1; bus_addr = 6'd18; bus_wdata = 16'hBEEF;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        check("R9", {15'd0, irq_out[2]}, 16'h0001);
        chk_rd("R9", 6'd18, 16'h0003);
        chk_rd("R9", 6'd34, 16'h0000);
        idle();
        check("R9", {15'd0, irq_out[2]}, 16'h0000);
        cap_in[2] = 1'b0;

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk_rd("R10", 6'd2, 16'h0000);
        chk_rd("R10", 6'd18, 16'h0000);
        rst_n = 1'b1;
        idle();
        summary();
    end
endmodule